// File: doc/BRIEF.md
# Boot ROM Overlay Bus Decoder

This block sits between an 8-bit processor and its memories in a 16-bit address space. It resolves every CPU access against three regions checked in a fixed order. The first is a 256-byte start-up ROM that overlays the bottom of the map. The second is a one-byte control register at 0xFF50. The third is a RAM region that ends at the top of the map. An address that no region claims reads as 0xFF, and a write to it has no effect.

The start-up ROM is filled from a side load port before the CPU starts. Any CPU write to the control register sets a sticky flag that removes the ROM overlay for good, so the decode of 0x0000 to 0x00FF changes while the system runs. Only reset brings the overlay back. Read data is registered and is valid one clock after the read strobe.

The RAM region has 2^RAM_AW bytes and its base is 0x10000 - 2^RAM_AW. The default of 12 keeps the storage small. A value of 15 gives the full region from 0x8000 to 0xFFFF.

Top module: `boot_overlay_decoder`

## Requirements
- R1: After reset, cpu_rdata is 0x00, the boot ROM overlay is mapped and the control register holds 0x00.
- R2: While the overlay is mapped, a read at 0x0000 to 0x00FF returns the ROM byte loaded at offset cpu_addr[7:0].
- R3: While the overlay is mapped, a CPU write to 0x0000 to 0x00FF is discarded and the ROM contents stay the same.
- R4: A read of 0xFF50 returns the last byte written there, or 0x00 if there has been no write since reset.
- R5: A write to 0xFF50 with any data value, 0x00 included, unmaps the overlay. From then on, 0x0000 to 0x00FF is unclaimed until the next reset.
- R6: The RAM region covers 0x10000 - 2^RAM_AW to 0xFFFF. It can be read and written, and each address selects its own byte at index address minus base.
- R7: A read of an unclaimed address returns 0xFF. A write to an unclaimed address changes nothing that can be read back.
- R8: The regions are served in the priority ROM overlay, then control register, then RAM. An access to 0xFF50 reaches the register, never the RAM byte underneath, and the neighbours 0xFF4F and 0xFF51 stay in RAM.
- R9: The load port writes rom_ld_data at offset rom_ld_addr in the same cycle, and only in a cycle in which cpu_rd and cpu_wr are both low. A load request made during a CPU access is dropped.
- R10: cpu_rdata is updated only on an edge at which cpu_rd is sampled high, and it holds its value otherwise. A write takes effect on the edge at which cpu_wr is sampled, so a read issued in the next cycle sees it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_addr | input | 16 | CPU address |
| cpu_wdata | input | 8 | CPU write data |
| cpu_rd | input | 1 | CPU read strobe |
| cpu_wr | input | 1 | CPU write strobe |
| cpu_rdata | output | 8 | Registered read data |
| rom_ld_en | input | 1 | Boot ROM load request |
| rom_ld_addr | input | 8 | Boot ROM load offset |
| rom_ld_data | input | 8 | Boot ROM load byte |

## Verification
The decoder is exercised with addresses at the edges of each region: the first and last ROM bytes, the register and the RAM bytes on either side of it, the RAM base and top, and the gap below the RAM. It also uses the same addresses before and after the overlay is removed. Comparing these pairs separates a correct priority order and a correct sticky flag from a decoder that mis-orders the regions or lets the flag depend on the written data. Further sequences show that ROM writes are discarded, that load requests are dropped during CPU accesses, that reset maps the overlay again, and that read data holds while no read is issued.

// File: rtl/boot_overlay_decoder.sv
module boot_overlay_decoder #(
  parameter int          RAM_AW    = 12,
  parameter logic [15:0] CTRL_ADDR = 16'hFF50,
  parameter logic [7:0]  FILL      = 8'hFF
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [15:0] cpu_addr,
  input  logic [7:0]  cpu_wdata,
  input  logic        cpu_rd,
  input  logic        cpu_wr,
  output logic [7:0]  cpu_rdata,
  input  logic        rom_ld_en,
  input  logic [7:0]  rom_ld_addr,
  input  logic [7:0]  rom_ld_data
);

  localparam int          RAM_DEPTH = 1 << RAM_AW;
  localparam logic [15:0] RAM_BASE  = 16'(32'h10000 - RAM_DEPTH);

  typedef enum logic [1:0] {SEL_NONE, SEL_ROM, SEL_CTRL, SEL_RAM} sel_t;

  logic [7:0]        rom_mem [256];
  logic [7:0]        ram_mem [RAM_DEPTH];
  logic              boot_off;
  logic [7:0]        ctrl_q;
  logic [RAM_AW-1:0] ram_idx;
  logic              hit_rom, hit_ctrl, hit_ram;
  sel_t              sel;

  assign hit_rom  = !boot_off && (cpu_addr[15:8] == 8'h00);
  assign hit_ctrl = (cpu_addr == CTRL_ADDR);
  assign hit_ram  = (cpu_addr >= RAM_BASE);
  assign ram_idx  = RAM_AW'(cpu_addr - RAM_BASE);

  always_comb begin
    if (hit_rom)       sel = SEL_ROM;
    else if (hit_ctrl) sel = SEL_CTRL;
    else if (hit_ram)  sel = SEL_RAM;
    else               sel = SEL_NONE;
  end

  always_ff @(posedge clk) begin
    if (rom_ld_en && !cpu_rd && !cpu_wr)
      rom_mem[rom_ld_addr] <= rom_ld_data;
  end

  always_ff @(posedge clk) begin
    if (cpu_wr && sel == SEL_RAM)
      ram_mem[ram_idx] <= cpu_wdata;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      boot_off <= 1'b0;
      ctrl_q   <= 8'h00;
    end else if (cpu_wr && sel == SEL_CTRL) begin
      boot_off <= 1'b1;
      ctrl_q   <= cpu_wdata;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)
      cpu_rdata <= 8'h00;
    else if (cpu_rd) begin
      case (sel)
        SEL_ROM:  cpu_rdata <= rom_mem[cpu_addr[7:0]];
        SEL_CTRL: cpu_rdata <= ctrl_q;
        SEL_RAM:  cpu_rdata <= ram_mem[ram_idx];
        default:  cpu_rdata <= FILL;
      endcase
    end
  end

  AST_UNCLAIMED_FILL: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_rd && !hit_rom && !hit_ctrl && !hit_ram |=> cpu_rdata == FILL); // R7
  AST_OVERLAY_GONE: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_rd && boot_off && cpu_addr[15:8] == 8'h00 |=> cpu_rdata == FILL); // R5
  AST_DISABLE_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    boot_off |=> boot_off); // R5
  AST_NO_SPURIOUS_DISABLE: assert property (@(posedge clk) disable iff (!rst_n)
    !boot_off && !(cpu_wr && cpu_addr == CTRL_ADDR) |=> !boot_off); // R5
  AST_CTRL_READBACK: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_rd && cpu_addr == CTRL_ADDR |=> cpu_rdata == $past(ctrl_q)); // R8
  AST_RDATA_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !cpu_rd && $past(rst_n) |=> $stable(cpu_rdata)); // R10

endmodule

// File: tb/test_boot_overlay_decoder.sv
module test_boot_overlay_decoder;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] cpu_addr = '0;
  logic [7:0]  cpu_wdata = '0;
  logic        cpu_rd = 1'b0;
  logic        cpu_wr = 1'b0;
  logic [7:0]  cpu_rdata;
  logic        rom_ld_en = 1'b0;
  logic [7:0]  rom_ld_addr = '0;
  logic [7:0]  rom_ld_data = '0;

  int checks = 0;
  int failures = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  boot_overlay_decoder i_boot_overlay_decoder (
    .clk(clk), .rst_n(rst_n), .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata),
    .cpu_rd(cpu_rd), .cpu_wr(cpu_wr), .cpu_rdata(cpu_rdata),
    .rom_ld_en(rom_ld_en), .rom_ld_addr(rom_ld_addr), .rom_ld_data(rom_ld_data)
  );

  function automatic logic [7:0] rom_pat(input logic [7:0] off);
    return off ^ 8'hA5;
  endfunction

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic wr(input logic [15:0] a, input logic [7:0] d);
    @(negedge clk);
    cpu_addr = a; cpu_wdata = d; cpu_wr = 1'b1;
    @(posedge clk);
    @(negedge clk);
    cpu_wr = 1'b0;
  endtask

  task automatic rd(input logic [15:0] a, output logic [7:0] d);
    @(negedge clk);
    cpu_addr = a; cpu_rd = 1'b1;
    @(posedge clk);
    @(negedge clk);
    cpu_rd = 1'b0;
    d = cpu_rdata;
  endtask

  task automatic load_rom();
    for (int i = 0; i < 256; i++) begin
      @(negedge clk);
      rom_ld_en = 1'b1; rom_ld_addr = 8'(i); rom_ld_data = rom_pat(8'(i));
    end
    @(negedge clk);
    rom_ld_en = 1'b0;
  endtask

  task automatic t_reset_state();
    logic [7:0] d;
    chk("R1 rdata after reset", cpu_rdata, 8'h00);
    rd(16'hFF50, d); chk("R1 ctrl after reset", d, 8'h00);
    rd(16'h0000, d); chk("R1 overlay mapped after reset", d, rom_pat(8'h00));
  endtask

  task automatic t_rom_reads();
    logic [7:0] d;
    rd(16'h0000, d); chk("R2 rom 0x0000", d, rom_pat(8'h00));
    rd(16'h007F, d); chk("R2 rom 0x007F", d, rom_pat(8'h7F));
    rd(16'h00FF, d); chk("R2 rom 0x00FF", d, rom_pat(8'hFF));
  endtask

  task automatic t_rom_write_ignored();
    logic [7:0] d;
    wr(16'h0005, 8'h00);
    rd(16'h0005, d); chk("R3 rom write discarded", d, rom_pat(8'h05));
  endtask

  task automatic t_ram();
    logic [7:0] d;
    wr(16'hF000, 8'h11);
    wr(16'hFFFF, 8'h22);
    wr(16'hFF4F, 8'h33);
    wr(16'hFF51, 8'h44);
    rd(16'hF000, d); chk("R6 ram base", d, 8'h11);
    rd(16'hFFFF, d); chk("R6 ram top", d, 8'h22);
    rd(16'hFF4F, d); chk("R8 ram below ctrl", d, 8'h33);
    rd(16'hFF51, d); chk("R8 ram above ctrl", d, 8'h44);
    wr(16'hF001, 8'h5A);
    rd(16'hF000, d); chk("R6 no aliasing", d, 8'h11);
    rd(16'hF001, d); chk("R10 write visible next read", d, 8'h5A);
  endtask

  task automatic t_unclaimed();
    logic [7:0] d;
    rd(16'h0100, d); chk("R7 unclaimed 0x0100", d, 8'hFF);
    rd(16'h7FFF, d); chk("R7 unclaimed 0x7FFF", d, 8'hFF);
    rd(16'hEFFF, d); chk("R7 unclaimed 0xEFFF", d, 8'hFF);
    wr(16'hEFFF, 8'h00);
    rd(16'hEFFF, d); chk("R7 unclaimed write no effect", d, 8'hFF);
    rd(16'hF000, d); chk("R7 ram untouched by unclaimed write", d, 8'h11);
  endtask

  task automatic t_load_blocked();
    logic [7:0] d;
    @(negedge clk);
    cpu_addr = 16'hF000; cpu_rd = 1'b1;
    rom_ld_en = 1'b1; rom_ld_addr = 8'h10; rom_ld_data = 8'h00;
    @(posedge clk);
    @(negedge clk);
    cpu_rd = 1'b0; cpu_addr = 16'hEFFF; cpu_wdata = 8'h00; cpu_wr = 1'b1;
    rom_ld_addr = 8'h11;
    @(posedge clk);
    @(negedge clk);
    cpu_wr = 1'b0; rom_ld_en = 1'b0;
    rd(16'h0010, d); chk("R9 load dropped during read", d, rom_pat(8'h10));
    rd(16'h0011, d); chk("R9 load dropped during write", d, rom_pat(8'h11));
  endtask

  task automatic t_hold();
    logic [7:0] d;
    rd(16'hFFFF, d);
    @(negedge clk);
    cpu_addr = 16'h0100;
    @(posedge clk);
    @(negedge clk);
    chk("R10 rdata holds without read", cpu_rdata, 8'h22);
  endtask

  task automatic t_disable();
    logic [7:0] d;
    wr(16'hFF50, 8'h00);
    rd(16'h0000, d); chk("R5 overlay gone after zero write", d, 8'hFF);
    rd(16'h00FF, d); chk("R5 overlay top gone", d, 8'hFF);
    rd(16'hFF50, d); chk("R4 ctrl readback 00", d, 8'h00);
    wr(16'hFF50, 8'h3C);
    rd(16'hFF50, d); chk("R4 ctrl readback 3C", d, 8'h3C);
    rd(16'h0080, d); chk("R5 still unmapped", d, 8'hFF);
    wr(16'h0080, 8'h77);
    rd(16'h0080, d); chk("R7 write to unmapped overlay", d, 8'hFF);
    rd(16'hFF4F, d); chk("R8 neighbour below intact", d, 8'h33);
    rd(16'hFF51, d); chk("R8 neighbour above intact", d, 8'h44);
  endtask

  task automatic t_reset_remap();
    logic [7:0] d;
    do_reset();
    chk("R1 rdata cleared by reset", cpu_rdata, 8'h00);
    rd(16'h0000, d); chk("R1 overlay remapped", d, rom_pat(8'h00));
    rd(16'hFF50, d); chk("R4 ctrl cleared by reset", d, 8'h00);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    load_rom();
    do_reset();
    t_reset_state();
    t_rom_reads();
    t_rom_write_ignored();
    t_ram();
    t_unclaimed();
    t_load_blocked();
    t_hold();
    t_disable();
    t_reset_remap();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule